// File: doc/BRIEF.md
# I2C Target Wakeup and Address Status Unit

This unit sits behind the synchronising input stage of an I2C target. It watches SCL and SDA, finds START and STOP conditions, and shifts in the first byte after each START, MSB first. That byte carries a 7-bit address and a read/write bit. The unit then decides whether the target acknowledges the address and reports that decision during the ninth clock. A small raw status register records three events: a START that woke the block from idle, a general-call address, and an address that selected this target. An enable register masks these bits onto a single interrupt line.

When the surrounding system is idle and the clock-activity setting allows the system clock to stop (setting 00 or 01), a START raises a wakeup request. The transfer that began with that START only serves to wake the block. Its address byte is refused with a NACK and leaves no address flags behind, so the master has to try again. For any other clock-activity setting the clock keeps running, no wakeup is raised, and the transfer is served as normal. Software reads and clears the status through a plain register port with combinational read data.

There is no streaming data path. Every pin is a plain control or status signal with no valid/ready handshake. A register write takes effect on the clock edge where `reg_wr_i` is high.

Top module: `i2c_tgt_wake`

## Requirements
- R1: After reset the status register and the enable register read 0, and `irq_o`, `wake_req_o`, `ack_phase_o` and `ack_drive_o` are all 0.
- R2: A START seen while `idle_i` is 1 and `clk_act_i[1]` is 0 sets status bit 6 (wake flag) and raises `wake_req_o`. `wake_req_o` stays high until `idle_i` goes low.
- R3: When `clk_act_i` is 10 or 11, a START never raises `wake_req_o` and never sets bit 6. The transfer is then answered as if the block were active.
- R4: The transfer whose START raised a wakeup is answered with a NACK (`ack_drive_o` = 0) and sets neither bit 5 nor bit 2.
- R5: An address byte of eight zero bits, in a transfer that did not cause a wakeup, is ACKed and sets both status bit 5 (general call) and status bit 2 (addressed).
- R6: An address byte whose upper seven bits equal `own_addr_i` is ACKed and sets bit 2, whatever the value of the R/W bit 0. Any other non-zero byte is NACKed and sets no flag.
- R7: `reg_addr_i` = 0 selects status and 1 selects enable. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Only bits 6, 5 and 2 exist in either register; all other bits read 0. While bit 5 is set, bit 2 reads 1.
- R8: If a hardware set and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R9: `irq_o` equals the OR of (status AND enable), registered, so it follows a change of either register one clock later.
- R10: `ack_phase_o` is high through the ninth SCL clock of the address byte. During that clock, `ack_drive_o` = 1 means SDA is to be pulled low (ACK).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| idle_i | input | 1 | System is in idle mode |
| clk_act_i | input | 2 | Clock-activity setting; 00/01 allow the clock to be stopped in idle |
| own_addr_i | input | ADDR_W | This target's 7-bit address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| irq_o | output | 1 | Interrupt request |
| wake_req_o | output | 1 | Wakeup request to the clock controller |
| ack_phase_o | output | 1 | Address acknowledge clock in progress |
| ack_drive_o | output | 1 | Pull SDA low for ACK during the acknowledge clock |

## Verification
The bench builds the block with a three-stage synchroniser (`SYNC_STAGES` = 3) and the default 7-bit address width. The extra stage lengthens the latency from a bus edge to the FSM, so the checks test whether the SCL phase spacing still leaves the acknowledge decision in place before the ninth rising edge. Both values of the R/W bit are driven against the own address, so the compare on the upper seven bits is exercised. Random draws of the idle level and all four clock-activity settings cover the boundary between settings that allow a wakeup and settings that do not.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int STAT_W  = 8;
  localparam int WAKE_B  = 6;
  localparam int GCALL_B = 5;
  localparam int SEL_B   = 2;
  localparam logic [STAT_W-1:0] IMPL_MASK = (STAT_W'(1) << WAKE_B) |
                                            (STAT_W'(1) << GCALL_B) |
                                            (STAT_W'(1) << SEL_B);
  localparam logic SEL_STATUS = 1'b0;
  localparam logic SEL_ENABLE = 1'b1;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_ADDR = 2'd1,
    RX_ACK  = 2'd2,
    RX_HOLD = 2'd3
  } rx_state_e;
endpackage

// File: rtl/wk_line_sync.sv
module wk_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[N-2:0], scl_i};
      sda_ff <= {sda_ff[N-2:0], sda_i};
      scl_q  <= scl_ff[N-1];
      sda_q  <= sda_ff[N-1];
    end
  end

  assign scl_s     = scl_ff[N-1];
  assign sda_s     = sda_ff[N-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  assert_start_stop_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));
endmodule

// File: rtl/wk_addr_rx.sv
module wk_addr_rx
  import wk_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic              wake_start,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              ack_phase_o,
  output logic              ack_drive_o,
  output logic              ev_gcall,
  output logic              ev_sel
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  rx_state_e          state;
  logic [BYTE_W-1:0]  shreg;
  logic [CNT_W-1:0]   cnt;
  logic               drop, ack_q;
  logic               gc_hit, own_hit;

  assign gc_hit  = (shreg == '0);
  assign own_hit = (shreg[BYTE_W-1:1] == own_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      shreg    <= '0;
      cnt      <= '0;
      drop     <= 1'b0;
      ack_q    <= 1'b0;
      ev_gcall <= 1'b0;
      ev_sel   <= 1'b0;
    end else begin
      ev_gcall <= 1'b0;
      ev_sel   <= 1'b0;
      if (start_det) begin
        state <= RX_ADDR;
        cnt   <= '0;
        drop  <= wake_start;
        ack_q <= 1'b0;
      end else if (stop_det) begin
        state <= RX_IDLE;
        drop  <= 1'b0;
        ack_q <= 1'b0;
      end else begin
        case (state)
          RX_ADDR: begin
            if (scl_rise && cnt != CNT_W'(BYTE_W)) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
              state    <= RX_ACK;
              ack_q    <= (gc_hit || own_hit) && !drop;
              ev_gcall <= gc_hit && !drop;
              ev_sel   <= (gc_hit || own_hit) && !drop;
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              state <= RX_HOLD;
              ack_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ack_phase_o = (state == RX_ACK);
  assign ack_drive_o = ack_q;

  // R4: a discarded transfer is never acknowledged
  assert_drop_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_ACK && drop) |-> !ack_q);
  // R10: the ACK drive only appears inside the acknowledge clock
  assert_ack_in_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (state == RX_ACK));
  // R5: a general-call event always comes with a selection event
  assert_gc_event_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_gcall |-> ev_sel);
endmodule

// File: rtl/wk_irq_regs.sv
module wk_irq_regs
  import wk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] rdata,
  output logic              irq_o
);
  logic [STAT_W-1:0] st, en, clr, st_base, st_nxt;

  assign clr     = (wr_en && addr == SEL_STATUS) ? (wdata & IMPL_MASK) : '0;
  assign st_base = ((st & ~clr) | set_vec) & IMPL_MASK;

  always_comb begin
    st_nxt        = st_base;
    st_nxt[SEL_B] = st_base[SEL_B] | st_base[GCALL_B];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= '0;
      en    <= '0;
      irq_o <= 1'b0;
    end else begin
      st <= st_nxt;
      if (wr_en && addr == SEL_ENABLE) en <= wdata & IMPL_MASK;
      irq_o <= |(st & en);
    end
  end

  assign rdata = (addr == SEL_ENABLE) ? en : st;

  // R7: general call implies addressed
  assert_gc_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st[GCALL_B] |-> st[SEL_B]);
  // R9: interrupt follows masked status one clock later
  assert_irq_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(st & en)));

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_impl
      // R7: writing 0 to a set bit keeps it
      assert_w0_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_STATUS && !wdata[b] && st[b]) |=> st[b]);
      // R8: a set in the cycle of a clear wins
      assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[b] |=> st[b]);
    end else begin : g_none
      assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !st[b] && !en[b]);
    end
  end
endmodule

// File: rtl/i2c_tgt_wake.sv
module i2c_tgt_wake
  import wk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              idle_i,
  input  logic [1:0]        clk_act_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  output logic [STAT_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              wake_req_o,
  output logic              ack_phase_o,
  output logic              ack_drive_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wake_evt, ev_gcall, ev_sel, wake_q;
  logic [STAT_W-1:0] set_vec;

  wk_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign wake_evt = start_det && idle_i && !clk_act_i[1];

  wk_addr_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .wake_start(wake_evt), .own_addr(own_addr_i),
    .ack_phase_o(ack_phase_o), .ack_drive_o(ack_drive_o),
    .ev_gcall(ev_gcall), .ev_sel(ev_sel)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[WAKE_B]  = wake_evt;
    set_vec[GCALL_B] = ev_gcall;
    set_vec[SEL_B]   = ev_sel;
  end

  wk_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .wr_en(reg_wr_i),
    .addr(reg_addr_i), .wdata(reg_wdata_i), .rdata(reg_rdata_o), .irq_o(irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wake_q <= 1'b0;
    else if (wake_evt)  wake_q <= 1'b1;
    else if (!idle_i)   wake_q <= 1'b0;
  end
  assign wake_req_o = wake_q;

  // R3: a wakeup only rises from idle with a clock-stopping setting
  assert_wake_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req_o) |-> ($past(idle_i) && !$past(clk_act_i[1])));
  // R2: the wake flag only appears together with a wakeup request
  assert_wake_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata_o[WAKE_B]) && reg_addr_i == SEL_STATUS |-> wake_req_o);
  // R2: the request holds while idle persists
  assert_wake_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req_o && idle_i) |=> wake_req_o);
endmodule

// File: tb/i2c_tgt_wake_tb.sv
module i2c_tgt_wake_tb;
  localparam logic [6:0] OWN = 7'h3A;
  localparam int HP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, idle = 1'b0;
  logic [1:0] cact = 2'b00;
  logic wr = 1'b0, ra = 1'b0;
  logic [7:0] wd = '0, rd;
  logic irq, wake, aph, adr;
  int checks = 0, errors = 0, irq_seen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_tgt_wake #(.SYNC_STAGES(3), .ADDR_W(7)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .idle_i(idle),
    .clk_act_i(cact), .own_addr_i(OWN), .reg_wr_i(wr), .reg_addr_i(ra),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .irq_o(irq), .wake_req_o(wake),
    .ack_phase_o(aph), .ack_drive_o(adr)
  );

  always @(negedge clk) if (irq) irq_seen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] v);
    @(negedge clk); ra = a; #1; v = rd;
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] v);
    @(negedge clk); ra = a; wd = v; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_start;
    sda = 1'b1; scl = 1'b1; waitc(HP);
    sda = 1'b0; waitc(HP);
    scl = 1'b0; waitc(HP);
  endtask

  task automatic bus_stop;
    sda = 1'b0; waitc(HP);
    scl = 1'b1; waitc(HP);
    sda = 1'b1; waitc(HP);
  endtask

  task automatic put_bit(input logic b);
    sda = b; waitc(HP);
    scl = 1'b1; waitc(HP);
    scl = 1'b0; waitc(HP);
  endtask

  task automatic send_addr(input logic [7:0] b, output logic phase, output logic ack);
    bus_start();
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda = 1'b1; waitc(HP);
    scl = 1'b1; waitc(HP);
    phase = aph; ack = adr;
    scl = 1'b0; waitc(HP);
  endtask

  function automatic logic exp_ack(input logic [7:0] b, input logic drop);
    return !drop && (b == 8'h00 || b[7:1] == OWN);
  endfunction

  function automatic logic [7:0] exp_stat(input logic [7:0] b, input logic drop);
    logic [7:0] s = '0;
    if (drop) s[6] = 1'b1;
    else begin
      if (b == 8'h00) begin s[5] = 1'b1; s[2] = 1'b1; end
      if (b[7:1] == OWN) s[2] = 1'b1;
    end
    return s;
  endfunction

  initial begin
    logic [7:0] v, b;
    logic ph, ak, drop;
    void'($urandom(32'd4242));
    waitc(3); rst_n = 1'b1; waitc(2);

    // R1 reset state
    rd_reg(1'b0, v); chk("R1 status", v, 8'h00);
    rd_reg(1'b1, v); chk("R1 enable", v, 8'h00);
    chk("R1 outs", {irq, wake, aph, adr}, 4'b0000);

    // R7 enable only keeps implemented bits
    wr_reg(1'b1, 8'hFF); rd_reg(1'b1, v); chk("R7 enable mask", v, 8'h64);
    wr_reg(1'b1, 8'h00);

    // R5 general call, R10 phase
    send_addr(8'h00, ph, ak); bus_stop();
    chk("R10 ack phase", ph, 1'b1); chk("R5 gc ack", ak, 1'b1);
    rd_reg(1'b0, v); chk("R5 gc flags", v, 8'h24);
    chk("R10 phase ends", aph, 1'b0);

    // R7 write 0 no effect, clear GC leaves AAS, then W1C
    wr_reg(1'b0, 8'h00); rd_reg(1'b0, v); chk("R7 write0 keeps", v, 8'h24);
    wr_reg(1'b0, 8'h04); rd_reg(1'b0, v); chk("R7 sel held by gc", v, 8'h24);
    wr_reg(1'b0, 8'h20); rd_reg(1'b0, v); chk("R7 gc cleared", v, 8'h04);
    wr_reg(1'b0, 8'h04); rd_reg(1'b0, v); chk("R7 all clear", v, 8'h00);

    // R9 irq through mask and timing
    wr_reg(1'b1, 8'h40);
    send_addr({OWN, 1'b1}, ph, ak); bus_stop();
    chk("R6 own ack rw1", ak, 1'b1);
    chk("R9 masked irq", irq, 1'b0);
    wr_reg(1'b1, 8'h04);
    chk("R9 irq lag", irq, 1'b0);
    @(negedge clk); chk("R9 irq set", irq, 1'b1);
    @(negedge clk); ra = 1'b0; wd = 8'h04; wr = 1'b1;
    @(negedge clk); wr = 1'b0; chk("R9 irq hold one clk", irq, 1'b1);
    @(negedge clk); chk("R9 irq cleared", irq, 1'b0);

    // R8 set wins against a continuous clear
    irq_seen = 0;
    @(negedge clk); ra = 1'b0; wd = 8'hFF; wr = 1'b1;
    send_addr({OWN, 1'b0}, ph, ak);
    chk("R8 set survived clear", (irq_seen > 0), 1'b1);
    bus_stop();
    wr = 1'b0; waitc(2);
    rd_reg(1'b0, v); chk("R8 cleared after", v, 8'h00);
    wr_reg(1'b1, 8'h00);

    // R2/R4 directed wake, then retry served
    idle = 1'b1; cact = 2'b01;
    send_addr({OWN, 1'b0}, ph, ak); bus_stop();
    chk("R4 wake nack", ak, 1'b0);
    chk("R2 wake req", wake, 1'b1);
    rd_reg(1'b0, v); chk("R2 R4 wake flags", v, 8'h40);
    idle = 1'b0; waitc(2); chk("R2 wake release", wake, 1'b0);
    send_addr({OWN, 1'b0}, ph, ak); bus_stop();
    chk("R4 retry ack", ak, 1'b1);
    wr_reg(1'b0, 8'hFF);

    // R3 no wake for clock kept running
    idle = 1'b1; cact = 2'b10;
    send_addr(8'h00, ph, ak); bus_stop();
    chk("R3 no wake", wake, 1'b0); chk("R3 served", ak, 1'b1);
    rd_reg(1'b0, v); chk("R3 flags", v, 8'h24);
    idle = 1'b0; wr_reg(1'b0, 8'hFF);

    // random mix
    for (int t = 0; t < 40; t++) begin
      int sel = $urandom_range(0, 3);
      b = (sel == 0) ? 8'h00 : (sel == 1) ? {OWN, 1'($urandom)} : 8'($urandom);
      idle = 1'($urandom);
      cact = 2'($urandom);
      drop = idle && !cact[1];
      send_addr(b, ph, ak); bus_stop();
      chk(drop ? "R4 rnd ack" : "R6 rnd ack", ak, exp_ack(b, drop));
      rd_reg(1'b0, v); chk(drop ? "R2 rnd stat" : "R5 rnd stat", v, exp_stat(b, drop));
      chk("R3 rnd wake", wake, drop);
      idle = 1'b0; waitc(2);
      wr_reg(1'b0, 8'hFF);
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule